// File: doc/BRIEF.md
# Serial Control Word Receiver with Frame-Synchronous Update

This block takes 12-bit control words from a three-line serial port (enable, clock, data) and turns them into the static settings of an image front end: a 9-bit gain code, an 8-bit level-setting DAC code, a 7-bit clamp reference code, and a set of active-level selects for the timing pulses. All serial lines and the frame sync input are brought into the system clock domain through two-stage synchronizers. Edges are found by oversampling, so the block has only one clock.

A word is two address bits followed by ten payload bits, most significant bit first. The address picks one of four banks. Each bank keeps only its own field and drops the reserved payload bits. The gain and clamp codes go into shadow registers first. They move to the live outputs only on the chosen edge of the frame sync input, so a setting never changes in the middle of a picture. A polarity bit selects that edge. The DAC code and the polarity selects apply as soon as the word is decoded. If a board has no frame sync, the enable line can be wired to the sync input with the falling edge selected. New gain and clamp codes then apply at the end of each word.

Top module: `ctrl3w_top`

## Requirements
- R1: After reset every output is 0 (gain, DAC, clamp, all polarity selects), so the rising frame-sync edge is the one selected.
- R2: Data is sampled on rising serial-clock edges only while enable is high, MSB first: A1, A0, SD9 … SD0. Serial-clock edges while enable is low change nothing.
- R3: A word is decoded when enable falls, and only if exactly 12 bits were clocked in. A burst of 11 or 13 bits leaves every output unchanged, and the next correct word is still accepted.
- R4: Address 00 loads SD8..SD0 into the gain shadow. SD9 is ignored, and the live gain output does not change at decode.
- R5: Address 01 loads SD7..SD0 into the DAC output on the cycle after decode. SD9 and SD8 are ignored.
- R6: Address 10 loads SD6..SD0 (0 to 127) into the clamp shadow. SD9..SD7 are ignored, and the live clamp output does not change at decode.
- R7: Address 11 sets the polarity selects at once: SD0 sets the sample pulses, SD1 the pixel clock, SD3 the optical-black clamp, SD5 blanking, and SD6 the frame-sync edge (0 rising, 1 falling). The dummy-pixel clamp select always reads 0. SD4 and SD9..SD7 are ignored.
- R8: The gain and clamp shadows move to the live outputs on the selected frame-sync edge only. The other edge, and cycles with no edge, leave the live outputs unchanged.
- R9: When a gain or clamp word is decoded in the same cycle as a selected sync edge, the live output takes the newly written value.
- R10: A write to one bank leaves the other banks' outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples all serial and sync lines |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk_i | input | 1 | Serial clock, data taken on its rising edge |
| ser_en_i | input | 1 | Serial enable, high during a word |
| ser_dat_i | input | 1 | Serial data, MSB first |
| fsync_i | input | 1 | Frame sync, transfer edge set by a polarity bit |
| gain_o | output | 9 | Live gain code |
| dac_o | output | 8 | DAC code |
| clamp_o | output | 7 | Live clamp reference code |
| pol_sample_o | output | 1 | Sample pulses active high when 1 |
| pol_pixclk_o | output | 1 | Pixel clock active high when 1 |
| pol_dummy_o | output | 1 | Dummy-pixel clamp select, always 0 |
| pol_obclamp_o | output | 1 | Optical-black clamp active high when 1 |
| pol_blank_o | output | 1 | Blanking active high when 1 |
| sync_fall_o | output | 1 | 1 selects the falling frame-sync edge |

## Verification
Word decode and the shadow-to-live transfer can happen in the same clock cycle. This occurs when the enable line also drives the frame sync input and the falling edge is selected. The bench provokes this case by selecting the falling edge and then tying its sync drive to the enable line. It then sends gain and clamp words. The live outputs must show the new code a few cycles after enable falls, with no extra sync pulse. Separate frame-sync pulses with the enable line held still exercise the normal path, on both edge settings, to show that the edge that is not selected does nothing.

// File: rtl/ctrl3w_pkg.sv
package ctrl3w_pkg;
    localparam int ADDR_W  = 2;
    localparam int DATA_W  = 10;
    localparam int WORD_W  = ADDR_W + DATA_W;
    localparam int GAIN_W  = 9;
    localparam int DAC_W   = 8;
    localparam int CLAMP_W = 7;
    localparam int SYNC_STAGES = 2;

    typedef enum logic [ADDR_W-1:0] {
        BANK_GAIN  = 2'b00,
        BANK_DAC   = 2'b01,
        BANK_CLAMP = 2'b10,
        BANK_POL   = 2'b11
    } bank_e;

    // payload bit positions of the polarity bank
    localparam int POL_SAMPLE_BIT  = 0;
    localparam int POL_PIXCLK_BIT  = 1;
    localparam int POL_OBCLAMP_BIT = 3;
    localparam int POL_BLANK_BIT   = 5;
    localparam int POL_SYNC_BIT    = 6;

    typedef struct packed {
        logic sync_fall;
        logic blank;
        logic obclamp;
        logic pixclk;
        logic sample;
    } pol_t;
endpackage

// File: rtl/ctrl3w_sync.sv
module ctrl3w_sync #(
    parameter int N      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] async_i,
    output logic [N-1:0] level_o,
    output logic [N-1:0] prev_o
);
    localparam int DEPTH = STAGES + 1;

    typedef struct packed {
        logic [DEPTH-1:0][N-1:0] chain;
    } state_t;

    state_t q, d;

    always_comb begin
        d = q;
        d.chain[0] = async_i;
        for (int s = 1; s < DEPTH; s++) begin
            d.chain[s] = q.chain[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign level_o = q.chain[STAGES-1];
    assign prev_o  = q.chain[STAGES];
endmodule

// File: rtl/ctrl3w_shift.sv
module ctrl3w_shift #(
    parameter int WORD_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_rise_i,
    input  logic              sen_lvl_i,
    input  logic              sen_fall_i,
    input  logic              sdat_i,
    output logic              word_vld_o,
    output logic [WORD_W-1:0] word_o,
    output logic [$clog2(WORD_W+2)-1:0] bit_cnt_o
);
    localparam int CNT_W   = $clog2(WORD_W + 2);
    localparam int CNT_SAT = WORD_W + 1;

    typedef struct packed {
        logic [WORD_W-1:0] shreg;
        logic [CNT_W-1:0]  cnt;
    } state_t;

    state_t q, d;

    always_comb begin
        d = q;
        if (sen_lvl_i) begin
            if (sclk_rise_i) begin
                d.shreg = {q.shreg[WORD_W-2:0], sdat_i};
                if (q.cnt != CNT_W'(CNT_SAT)) d.cnt = q.cnt + 1'b1;
            end
        end else begin
            d.cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign word_vld_o = sen_fall_i && (q.cnt == CNT_W'(WORD_W));
    assign word_o     = q.shreg;
    assign bit_cnt_o  = q.cnt;
endmodule

// File: rtl/ctrl3w_regbank.sv
module ctrl3w_regbank
    import ctrl3w_pkg::*;
#(
    parameter int G_W = GAIN_W,
    parameter int D_W = DAC_W,
    parameter int C_W = CLAMP_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              word_vld_i,
    input  logic [WORD_W-1:0] word_i,
    input  logic              fsync_rise_i,
    input  logic              fsync_fall_i,
    output logic              sync_take_o,
    output logic [G_W-1:0]    gain_o,
    output logic [D_W-1:0]    dac_o,
    output logic [C_W-1:0]    clamp_o,
    output pol_t              pol_o
);
    typedef struct packed {
        logic [G_W-1:0] gain_sh;
        logic [G_W-1:0] gain_lv;
        logic [C_W-1:0] clamp_sh;
        logic [C_W-1:0] clamp_lv;
        logic [D_W-1:0] dac;
        pol_t           pol;
    } state_t;

    state_t q, d;
    bank_e  addr;
    logic   take;
    logic   reserved_unused;

    assign reserved_unused = ^{word_i[DATA_W-1], word_i[4], word_i[2]};

    always_comb begin
        d    = q;
        addr = bank_e'(word_i[WORD_W-1 -: ADDR_W]);
        take = q.pol.sync_fall ? fsync_fall_i : fsync_rise_i;
        if (word_vld_i) begin
            case (addr)
                BANK_GAIN:  d.gain_sh  = word_i[G_W-1:0];
                BANK_DAC:   d.dac      = word_i[D_W-1:0];
                BANK_CLAMP: d.clamp_sh = word_i[C_W-1:0];
                BANK_POL: begin
                    d.pol.sample    = word_i[POL_SAMPLE_BIT];
                    d.pol.pixclk    = word_i[POL_PIXCLK_BIT];
                    d.pol.obclamp   = word_i[POL_OBCLAMP_BIT];
                    d.pol.blank     = word_i[POL_BLANK_BIT];
                    d.pol.sync_fall = word_i[POL_SYNC_BIT];
                end
                default: ;
            endcase
        end
        if (take) begin
            d.gain_lv  = d.gain_sh;
            d.clamp_lv = d.clamp_sh;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign sync_take_o = take;
    assign gain_o      = q.gain_lv;
    assign clamp_o     = q.clamp_lv;
    assign dac_o       = q.dac;
    assign pol_o       = q.pol;
endmodule

// File: rtl/ctrl3w_top.sv
module ctrl3w_top
    import ctrl3w_pkg::*;
#(
    parameter int G_W = GAIN_W,
    parameter int D_W = DAC_W,
    parameter int C_W = CLAMP_W
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           ser_clk_i,
    input  logic           ser_en_i,
    input  logic           ser_dat_i,
    input  logic           fsync_i,
    output logic [G_W-1:0] gain_o,
    output logic [D_W-1:0] dac_o,
    output logic [C_W-1:0] clamp_o,
    output logic           pol_sample_o,
    output logic           pol_pixclk_o,
    output logic           pol_dummy_o,
    output logic           pol_obclamp_o,
    output logic           pol_blank_o,
    output logic           sync_fall_o
);
    localparam int NSYNC = 4;
    localparam int CNT_W = $clog2(WORD_W + 2);

    logic [NSYNC-1:0]  lvl, prev;
    logic              sclk_rise, sen_fall, fs_rise, fs_fall;
    logic              word_vld, sync_take;
    logic [WORD_W-1:0] word;
    logic [CNT_W-1:0]  bit_cnt;
    pol_t              pol;
    logic              prev_unused;

    // lane order: 3 fsync, 2 enable, 1 serial clock, 0 data
    ctrl3w_sync #(.N(NSYNC), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({fsync_i, ser_en_i, ser_clk_i, ser_dat_i}),
        .level_o (lvl),
        .prev_o  (prev)
    );

    assign sclk_rise   = lvl[1] & ~prev[1];
    assign sen_fall    = ~lvl[2] & prev[2];
    assign fs_rise     = lvl[3] & ~prev[3];
    assign fs_fall     = ~lvl[3] & prev[3];
    assign prev_unused = prev[0];

    ctrl3w_shift #(.WORD_W(WORD_W)) u_shift (
        .clk         (clk),
        .rst_n       (rst_n),
        .sclk_rise_i (sclk_rise),
        .sen_lvl_i   (lvl[2]),
        .sen_fall_i  (sen_fall),
        .sdat_i      (lvl[0]),
        .word_vld_o  (word_vld),
        .word_o      (word),
        .bit_cnt_o   (bit_cnt)
    );

    ctrl3w_regbank #(.G_W(G_W), .D_W(D_W), .C_W(C_W)) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .word_vld_i   (word_vld),
        .word_i       (word),
        .fsync_rise_i (fs_rise),
        .fsync_fall_i (fs_fall),
        .sync_take_o  (sync_take),
        .gain_o       (gain_o),
        .dac_o        (dac_o),
        .clamp_o      (clamp_o),
        .pol_o        (pol)
    );

    assign pol_sample_o  = pol.sample;
    assign pol_pixclk_o  = pol.pixclk;
    assign pol_dummy_o   = 1'b0;
    assign pol_obclamp_o = pol.obclamp;
    assign pol_blank_o   = pol.blank;
    assign sync_fall_o   = pol.sync_fall;
endmodule

// File: rtl/ctrl3w_chk.sv
module ctrl3w_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        word_vld,
    input logic [11:0] word,
    input logic        sync_take,
    input logic [3:0]  bit_cnt,
    input logic [8:0]  gain_o,
    input logic [7:0]  dac_o,
    input logic [6:0]  clamp_o,
    input logic [4:0]  pol_vec
);
    AST_RESET_CLEAR: assert property (@(posedge clk)
        !rst_n |=> (gain_o == '0 && dac_o == '0 && clamp_o == '0 && pol_vec == '0)); // R1

    AST_CNT_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
        bit_cnt <= 4'd13); // R3

    AST_DAC_ONLY_ON_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        !(word_vld && word[11:10] == 2'b01) |=> $stable(dac_o)); // R5

    AST_POL_ONLY_ON_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        !(word_vld && word[11:10] == 2'b11) |=> $stable(pol_vec)); // R7

    AST_LIVE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !sync_take |=> ($stable(gain_o) && $stable(clamp_o))); // R8

    AST_GAIN_COLLIDE: assert property (@(posedge clk) disable iff (!rst_n)
        (word_vld && sync_take && word[11:10] == 2'b00) |=> gain_o == $past(word[8:0])); // R9
endmodule

bind ctrl3w_top ctrl3w_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .word_vld  (word_vld),
    .word      (word),
    .sync_take (sync_take),
    .bit_cnt   (bit_cnt),
    .gain_o    (gain_o),
    .dac_o     (dac_o),
    .clamp_o   (clamp_o),
    .pol_vec   ({sync_fall_o, pol_blank_o, pol_obclamp_o, pol_pixclk_o, pol_sample_o})
);

// File: tb/tb_ctrl3w_top.sv
module tb_ctrl3w_top;
    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic rst_n, sclk, sen, sdat, fsync_r, tie_mode, fsync_drv;
    always_comb fsync_drv = tie_mode ? sen : fsync_r;

    logic [8:0] gain_o;
    logic [7:0] dac_o;
    logic [6:0] clamp_o;
    logic pol_sample_o, pol_pixclk_o, pol_dummy_o, pol_obclamp_o, pol_blank_o, sync_fall_o;

    ctrl3w_top dut (
        .clk(clk), .rst_n(rst_n),
        .ser_clk_i(sclk), .ser_en_i(sen), .ser_dat_i(sdat), .fsync_i(fsync_drv),
        .gain_o(gain_o), .dac_o(dac_o), .clamp_o(clamp_o),
        .pol_sample_o(pol_sample_o), .pol_pixclk_o(pol_pixclk_o), .pol_dummy_o(pol_dummy_o),
        .pol_obclamp_o(pol_obclamp_o), .pol_blank_o(pol_blank_o), .sync_fall_o(sync_fall_o)
    );

    int n_chk = 0;
    int n_bad = 0;

    // reference model: {sync_fall, blank, obclamp, pixclk, sample}
    logic [8:0] e_gain_sh, e_gain;
    logic [6:0] e_clamp_sh, e_clamp;
    logic [7:0] e_dac;
    logic [4:0] e_pol;

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req);
        logic [29:0] act, exp;
        act = {gain_o, dac_o, clamp_o, sync_fall_o, pol_blank_o, pol_obclamp_o,
               pol_pixclk_o, pol_sample_o, pol_dummy_o};
        exp = {e_gain, e_dac, e_clamp, e_pol, 1'b0};
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic take();
        e_gain  = e_gain_sh;
        e_clamp = e_clamp_sh;
    endtask

    task automatic apply(input logic [11:0] w);
        case (w[11:10])
            2'b00: e_gain_sh  = w[8:0];
            2'b01: e_dac      = w[7:0];
            2'b10: e_clamp_sh = w[6:0];
            default: e_pol = {w[6], w[5], w[3], w[1], w[0]};
        endcase
    endtask

    task automatic shift_bits(input int n, input logic [15:0] bits);
        sen = 1'b1;
        wait_clk(3);
        for (int k = n - 1; k >= 0; k--) begin
            sdat = bits[k];
            wait_clk(3);
            sclk = 1'b1;
            wait_clk(3);
            sclk = 1'b0;
        end
        wait_clk(3);
        sen  = 1'b0;
        sdat = 1'b0;
        wait_clk(8);
    endtask

    task automatic send_word(input logic [11:0] w);
        shift_bits(12, {4'h0, w});
        apply(w);
        if (tie_mode && e_pol[4]) take();
    endtask

    task automatic pulse_sync();
        fsync_r = 1'b1;
        wait_clk(8);
        if (!e_pol[4]) take();
        check("R8 edge");
        fsync_r = 1'b0;
        wait_clk(8);
        if (e_pol[4]) take();
        check("R8 edge");
    endtask

    initial begin
        repeat (195000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; sclk = 1'b0; sen = 1'b0; sdat = 1'b0; fsync_r = 1'b0; tie_mode = 1'b0;
        e_gain_sh = '0; e_gain = '0; e_clamp_sh = '0; e_clamp = '0; e_dac = '0; e_pol = '0;
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(3);
        check("R1 reset");

        // R2: serial clock activity with enable low
        sdat = 1'b1;
        for (int k = 0; k < 6; k++) begin
            sclk = 1'b1; wait_clk(3); sclk = 1'b0; wait_clk(3);
        end
        sdat = 1'b0;
        wait_clk(4);
        check("R2 idle clocks");
        send_word(12'b01_00_1010_0101);
        check("R2 msb first");

        // R3: wrong bit counts are discarded
        shift_bits(11, 16'h03C);
        check("R3 short word");
        shift_bits(13, 16'h0BFF);
        check("R3 long word");
        send_word(12'b01_00_0011_1100);
        check("R3 recovery");

        // R4 and R8: gain sweep, shadow first, live on rising edge
        for (int i = 0; i < 512; i++) begin
            logic [8:0] g;
            g = 9'(i);
            send_word({2'b00, ^g, g});
            check("R4 R10 gain shadow");
            pulse_sync();
        end

        // R5: DAC sweep with reserved bits varied
        for (int i = 0; i < 256; i++) begin
            logic [7:0] v;
            v = 8'(i);
            send_word({2'b01, v[1:0] ^ 2'b10, v});
            check("R5 R10 dac");
        end

        // R6: clamp sweep
        for (int i = 0; i < 128; i++) begin
            logic [6:0] c;
            c = 7'(i);
            send_word({2'b10, c[2:0], c});
            check("R6 R10 clamp shadow");
            pulse_sync();
        end

        // R7: polarity sweep incl. dummy bit SD2 and unused SD4
        for (int i = 0; i < 128; i++) begin
            logic [6:0] p;
            p = 7'(i);
            send_word({2'b11, p[2:0], p});
            check("R7 polarity");
        end

        // R8: falling edge selected
        send_word(12'b11_000_1000000);
        check("R7 sync falling");
        send_word(12'b00_0_101010101);
        check("R4 pending");
        pulse_sync();
        send_word(12'b10_000_1011010);
        check("R6 pending");
        pulse_sync();

        // R9: enable tied to frame sync, falling edge selected
        tie_mode = 1'b1;
        wait_clk(4);
        send_word(12'b00_0_010101011);
        check("R9 gain collide");
        send_word(12'b10_000_0110011);
        check("R9 clamp collide");
        send_word(12'b00_1_111000111);
        check("R9 gain collide");
        tie_mode = 1'b0;
        wait_clk(6);
        check("R9 untie");

        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule